// File: doc/BRIEF.md
# Message Buffer Interrupt Vector Unit

This block sits beside the protocol engine of a serial bus controller and keeps one interrupt status flag, one enable bit and one direction bit for each of sixteen message buffers. The protocol engine pulses a per-buffer event line when a buffer needs attention. Software acknowledges a buffer by writing 1 to its flag. Every enabled, pending buffer is a candidate for one of two read-only vector registers. Receive buffers feed the receive vector, which names the lowest-numbered candidate. Transmit buffers feed the transmit vector, which names the highest-numbered candidate. Each vector has a summary flag. The vector holds its idle value whenever that summary flag is clear.

The unit also holds two interrupt enables, one for locking errors and one for wake-up requests, and drives a single general interrupt line. A mode state machine has two states. MODE_RUN is normal operation. MODE_SOFT is the soft-reset state. The machine moves from MODE_RUN to MODE_SOFT when software writes 1 to the soft-reset control bit, or when a locking error arrives while its enable is set. It moves from MODE_SOFT back to MODE_RUN when software writes 0 to that bit, unless an enabled locking error arrives in the same cycle. While the machine is in MODE_SOFT, the flags are cleared and both vectors show their idle values. The locking-error enable can only be changed in MODE_SOFT.

Top module: `msgbuf_irq_vec`

## Requirements
- R1: A one-cycle pulse on `flag_set[i]` sets `flag_q[i]` at the next clock edge. Writing with `flag_clr_wr` and `flag_clr_mask[i]`=1 clears it at the next edge. When a set and a clear for the same buffer fall in one cycle, the flag ends up set.
- R2: `rx_vec_reg[3:0]` holds the lowest index i for which `flag_q[i]`, `ena_q[i]` are both 1 and direction bit `dir_q[i]` is 0 (receive).
- R3: `tx_vec_reg[3:0]` holds the highest index i for which `flag_q[i]`, `ena_q[i]` are both 1 and `dir_q[i]` is 1 (transmit).
- R4: Both vector registers are 8 bits wide. The index sits in bits 3..0, and bits 7..4 always read 0.
- R5: `rx_sum` and `tx_sum` are 1 exactly when their candidate set is non-empty. While `rx_sum` is 0, `rx_vec_reg` reads 0x00. While `tx_sum` is 0, `tx_vec_reg` reads 0x0F.
- R6: Writing 1 with `srst_wr` puts the unit in soft reset from the next edge, and `srst_active` goes to 1. Writing 0 leaves soft reset. While soft reset is active, the summaries are 0, the vectors read their idle values, the flags clear, and `flag_set` pulses are ignored.
- R7: A write with `ien_wr` always loads `wake_en_q`. It loads `lock_en_q` only while `srst_active` is 1. In any other cycle the lock bit of the write is ignored.
- R8: When `lock_en_q`=1, a `lock_err` pulse raises `irq` in the same cycle and sets `srst_active` from the next edge. When `lock_en_q`=0, the pulse does neither.
- R9: When `wake_en_q`=1, a `wake_req` pulse raises `irq` in the same cycle. When `wake_en_q`=0, it does not.
- R10: `irq` is 1 whenever `rx_sum` or `tx_sum` is 1, and 0 when neither summary nor an enabled event is present.
- R11: A buffer whose enable bit `ena_q[i]` is 0 is never a candidate, even if its flag is set.
- R12: Hard reset (`rst_n`=0) clears all flags, enables and directions, both interrupt enables and the soft-reset state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hard reset |
| srst_wr | input | 1 | Write strobe for the soft-reset control bit |
| srst_wdata | input | 1 | Value written to the soft-reset control bit |
| srst_active | output | 1 | 1 while the unit is in soft reset |
| ien_wr | input | 1 | Write strobe for the interrupt-enable register |
| ien_lock_wdata | input | 1 | Locking-error enable value |
| ien_wake_wdata | input | 1 | Wake-up enable value |
| lock_en_q | output | 1 | Locking-error enable |
| wake_en_q | output | 1 | Wake-up enable |
| ena_wr | input | 1 | Write strobe for buffer enables |
| ena_wdata | input | 16 | Buffer enable bits |
| dir_wr | input | 1 | Write strobe for buffer directions |
| dir_wdata | input | 16 | Direction bits, 1 = transmit |
| flag_set | input | 16 | Per-buffer event pulses |
| flag_clr_wr | input | 1 | Write strobe for the write-1-to-clear of flags |
| flag_clr_mask | input | 16 | Flags to clear |
| lock_err | input | 1 | Locking error event pulse |
| wake_req | input | 1 | Wake-up request pulse |
| flag_q | output | 16 | Buffer status flags |
| ena_q | output | 16 | Buffer enables |
| dir_q | output | 16 | Buffer directions |
| rx_vec_reg | output | 8 | Receive vector register |
| tx_vec_reg | output | 8 | Transmit vector register |
| rx_sum | output | 1 | Receive summary flag |
| tx_sum | output | 1 | Transmit summary flag |
| irq | output | 1 | General interrupt |

## Verification
Two functions of this block can act on the same flag in the same cycle: an event pulse from the protocol engine that sets a flag, and a software write-1-to-clear of that flag. The bench provokes this by driving `flag_set` and a full `flag_clr_mask` in one cycle, with other flags already pending. It then expects the pulsed flag alone to survive and the vectors to follow. The bench also makes a locking error coincide with a pending buffer. It judges the same-cycle `irq` and then confirms that the next edge clears the summaries through soft reset.

// File: rtl/mbiv_pkg.sv
package mbiv_pkg;
    typedef enum logic [0:0] {
        MODE_RUN  = 1'b0,
        MODE_SOFT = 1'b1
    } mode_e;

    localparam int REG_W = 8;
endpackage

// File: rtl/mbiv_mode_fsm.sv
module mbiv_mode_fsm
    import mbiv_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  srst_wr,
    input  logic  srst_wdata,
    input  logic  ien_wr,
    input  logic  ien_lock_wdata,
    input  logic  ien_wake_wdata,
    input  logic  lock_err,
    output mode_e mode,
    output logic  lock_en,
    output logic  wake_en
);
    mode_e mode_nxt;
    logic  lock_trip;

    assign lock_trip = lock_err && lock_en;

    always_comb begin
        mode_nxt = mode;
        unique case (mode)
            MODE_RUN: begin
                if (lock_trip || (srst_wr && srst_wdata))
                    mode_nxt = MODE_SOFT;
            end
            MODE_SOFT: begin
                if (srst_wr && !srst_wdata && !lock_trip)
                    mode_nxt = MODE_RUN;
            end
            default: mode_nxt = MODE_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode <= MODE_RUN;
        else        mode <= mode_nxt;
    end

    // enable register; lock bit is guarded by the soft-reset state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock_en <= 1'b0;
            wake_en <= 1'b0;
        end else if (ien_wr) begin
            wake_en <= ien_wake_wdata;
            if (mode == MODE_SOFT)
                lock_en <= ien_lock_wdata;
        end
    end

    // R7: lock enable cannot move outside soft reset
    a_r7_lock_guard: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RUN) |=> $stable(lock_en));

    // R8: enabled locking error forces soft reset
    a_r8_lock_trip: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_err && lock_en) |=> (mode == MODE_SOFT));

    // R6: release write leaves soft reset unless a trip coincides
    a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SOFT && srst_wr && !srst_wdata && !(lock_err && lock_en))
        |=> (mode == MODE_RUN));
endmodule

// File: rtl/mbiv_flag_bank.sv
module mbiv_flag_bank #(
    parameter int NUM_BUF = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_all,
    input  logic [NUM_BUF-1:0] set_i,
    input  logic               clr_wr,
    input  logic [NUM_BUF-1:0] clr_mask,
    input  logic               ena_wr,
    input  logic [NUM_BUF-1:0] ena_wdata,
    input  logic               dir_wr,
    input  logic [NUM_BUF-1:0] dir_wdata,
    output logic [NUM_BUF-1:0] flag_q,
    output logic [NUM_BUF-1:0] ena_q,
    output logic [NUM_BUF-1:0] dir_q
);
    for (genvar g = 0; g < NUM_BUF; g++) begin : g_buf
        logic clr_hit;
        assign clr_hit = clr_wr && clr_mask[g];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          flag_q[g] <= 1'b0;
            else if (clr_all)    flag_q[g] <= 1'b0;
            else if (set_i[g])   flag_q[g] <= 1'b1;
            else if (clr_hit)    flag_q[g] <= 1'b0;
        end

        // R1: an event pulse outside soft reset always leaves the flag set
        a_r1_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr_all && set_i[g]) |=> flag_q[g]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ena_q <= '0;
            dir_q <= '0;
        end else begin
            if (ena_wr) ena_q <= ena_wdata;
            if (dir_wr) dir_q <= dir_wdata;
        end
    end

    // R6: soft reset empties every flag
    a_r6_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (flag_q == '0));
endmodule

// File: rtl/mbiv_prio_enc.sv
module mbiv_prio_enc #(
    parameter int               N         = 16,
    parameter int               W         = 4,
    parameter bit               LOW_FIRST = 1'b1,
    parameter logic [W-1:0]     IDLE_VAL  = '0
) (
    input  logic [N-1:0] cand,
    output logic [W-1:0] vec,
    output logic         any
);
    logic [W-1:0] pick;

    if (LOW_FIRST) begin : g_low
        always_comb begin
            pick = '0;
            for (int i = N - 1; i >= 0; i--)
                if (cand[i]) pick = W'(i);
        end
    end else begin : g_high
        always_comb begin
            pick = '0;
            for (int i = 0; i < N; i++)
                if (cand[i]) pick = W'(i);
        end
    end

    assign any = |cand;
    assign vec = any ? pick : IDLE_VAL;
endmodule

// File: rtl/msgbuf_irq_vec.sv
module msgbuf_irq_vec
    import mbiv_pkg::*;
#(
    parameter int NUM_BUF = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               srst_wr,
    input  logic               srst_wdata,
    output logic               srst_active,
    input  logic               ien_wr,
    input  logic               ien_lock_wdata,
    input  logic               ien_wake_wdata,
    output logic               lock_en_q,
    output logic               wake_en_q,
    input  logic               ena_wr,
    input  logic [NUM_BUF-1:0] ena_wdata,
    input  logic               dir_wr,
    input  logic [NUM_BUF-1:0] dir_wdata,
    input  logic [NUM_BUF-1:0] flag_set,
    input  logic               flag_clr_wr,
    input  logic [NUM_BUF-1:0] flag_clr_mask,
    input  logic               lock_err,
    input  logic               wake_req,
    output logic [NUM_BUF-1:0] flag_q,
    output logic [NUM_BUF-1:0] ena_q,
    output logic [NUM_BUF-1:0] dir_q,
    output logic [REG_W-1:0]   rx_vec_reg,
    output logic [REG_W-1:0]   tx_vec_reg,
    output logic               rx_sum,
    output logic               tx_sum,
    output logic               irq
);
    localparam int                 VEC_W   = $clog2(NUM_BUF);
    localparam logic [VEC_W-1:0]   RX_IDLE = '0;
    localparam logic [VEC_W-1:0]   TX_IDLE = '1;
    localparam logic [NUM_BUF-1:0] ONE     = NUM_BUF'(1);

    mode_e              mode;
    logic               running;
    logic [NUM_BUF-1:0] pend;
    logic [NUM_BUF-1:0] rx_cand;
    logic [NUM_BUF-1:0] tx_cand;
    logic [VEC_W-1:0]   rx_vec;
    logic [VEC_W-1:0]   tx_vec;

    mbiv_mode_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .srst_wr        (srst_wr),
        .srst_wdata     (srst_wdata),
        .ien_wr         (ien_wr),
        .ien_lock_wdata (ien_lock_wdata),
        .ien_wake_wdata (ien_wake_wdata),
        .lock_err       (lock_err),
        .mode           (mode),
        .lock_en        (lock_en_q),
        .wake_en        (wake_en_q)
    );

    assign running     = (mode == MODE_RUN);
    assign srst_active = !running;

    mbiv_flag_bank #(.NUM_BUF(NUM_BUF)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_all   (!running),
        .set_i     (flag_set),
        .clr_wr    (flag_clr_wr),
        .clr_mask  (flag_clr_mask),
        .ena_wr    (ena_wr),
        .ena_wdata (ena_wdata),
        .dir_wr    (dir_wr),
        .dir_wdata (dir_wdata),
        .flag_q    (flag_q),
        .ena_q     (ena_q),
        .dir_q     (dir_q)
    );

    assign pend    = flag_q & ena_q & {NUM_BUF{running}};
    assign rx_cand = pend & ~dir_q;
    assign tx_cand = pend & dir_q;

    mbiv_prio_enc #(.N(NUM_BUF), .W(VEC_W), .LOW_FIRST(1'b1), .IDLE_VAL(RX_IDLE)) u_rx_enc (
        .cand (rx_cand),
        .vec  (rx_vec),
        .any  (rx_sum)
    );

    mbiv_prio_enc #(.N(NUM_BUF), .W(VEC_W), .LOW_FIRST(1'b0), .IDLE_VAL(TX_IDLE)) u_tx_enc (
        .cand (tx_cand),
        .vec  (tx_vec),
        .any  (tx_sum)
    );

    assign rx_vec_reg = {{(REG_W - VEC_W){1'b0}}, rx_vec};
    assign tx_vec_reg = {{(REG_W - VEC_W){1'b0}}, tx_vec};

    assign irq = rx_sum || tx_sum || (lock_err && lock_en_q) || (wake_req && wake_en_q);

    // R2: receive vector names a candidate with no lower candidate
    a_r2_rx_lowest: assert property (@(posedge clk) disable iff (!rst_n)
        rx_sum |-> (rx_cand[rx_vec] && ((rx_cand & ((ONE << rx_vec) - ONE)) == '0)));

    // R3: transmit vector names a candidate with no higher candidate
    a_r3_tx_highest: assert property (@(posedge clk) disable iff (!rst_n)
        tx_sum |-> ((tx_cand >> tx_vec) == ONE));

    // R5: idle values while summaries are clear
    a_r5_rx_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_sum |-> (rx_vec_reg == 8'h00));
    a_r5_tx_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_sum |-> (tx_vec_reg == 8'h0F));

    // R6: no summary during soft reset
    a_r6_soft_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        srst_active |-> (!rx_sum && !tx_sum));

    // R9: enabled wake-up reaches the interrupt line
    a_r9_wake_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_req && wake_en_q) |-> irq);

    // R10: any summary reaches the interrupt line
    a_r10_sum_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_sum || tx_sum) |-> irq);
endmodule

// File: tb/msgbuf_irq_vec_bench.sv
`timescale 1ns/1ps
module msgbuf_irq_vec_bench;
    localparam int N = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         srst_wr = 0, srst_wdata = 0;
    logic         ien_wr = 0, ien_lock_wdata = 0, ien_wake_wdata = 0;
    logic         ena_wr = 0, dir_wr = 0, flag_clr_wr = 0;
    logic [N-1:0] ena_wdata = '0, dir_wdata = '0, flag_set = '0, flag_clr_mask = '0;
    logic         lock_err = 0, wake_req = 0;
    logic         srst_active, lock_en_q, wake_en_q, rx_sum, tx_sum, irq;
    logic [N-1:0] flag_q, ena_q, dir_q;
    logic [7:0]   rx_vec_reg, tx_vec_reg;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    msgbuf_irq_vec u_msgbuf_irq_vec (
        .clk(clk), .rst_n(rst_n),
        .srst_wr(srst_wr), .srst_wdata(srst_wdata), .srst_active(srst_active),
        .ien_wr(ien_wr), .ien_lock_wdata(ien_lock_wdata), .ien_wake_wdata(ien_wake_wdata),
        .lock_en_q(lock_en_q), .wake_en_q(wake_en_q),
        .ena_wr(ena_wr), .ena_wdata(ena_wdata), .dir_wr(dir_wr), .dir_wdata(dir_wdata),
        .flag_set(flag_set), .flag_clr_wr(flag_clr_wr), .flag_clr_mask(flag_clr_mask),
        .lock_err(lock_err), .wake_req(wake_req),
        .flag_q(flag_q), .ena_q(ena_q), .dir_q(dir_q),
        .rx_vec_reg(rx_vec_reg), .tx_vec_reg(tx_vec_reg),
        .rx_sum(rx_sum), .tx_sum(tx_sum), .irq(irq)
    );

    // stimulus table: {flag pulses, enables, directions}
    localparam int NV = 9;
    localparam logic [47:0] VEC_TAB [NV] = '{
        {16'h0000, 16'hFFFF, 16'h0000},
        {16'h0001, 16'hFFFF, 16'h0000},
        {16'h8000, 16'hFFFF, 16'h8000},
        {16'h0F0F, 16'hFFFF, 16'h00F0},
        {16'hA5A4, 16'hFFF0, 16'h0F00},
        {16'hFFFF, 16'h0000, 16'h5555},
        {16'h0180, 16'h0100, 16'h0100},
        {16'h7FFE, 16'hFFFF, 16'h4002},
        {16'hFFFF, 16'hFFFF, 16'hAAAA}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_low(input logic [N-1:0] c);
        ref_low = 8'h00;
        for (int i = 0; i < N; i++)
            if (c[i]) return 8'(i);
    endfunction

    function automatic logic [7:0] ref_high(input logic [N-1:0] c);
        ref_high = 8'h0F;
        for (int i = N - 1; i >= 0; i--)
            if (c[i]) return 8'(i);
    endfunction

    task automatic edge_step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        srst_wr = 0; ien_wr = 0; ena_wr = 0; dir_wr = 0; flag_clr_wr = 0;
        flag_set = '0; flag_clr_mask = '0; lock_err = 0; wake_req = 0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [N-1:0] rc, tc;
        repeat (3) @(negedge clk);
        // R12 / R5: reset state
        chk("R12 flags", 32'(flag_q), 0);
        chk("R12 enables", 32'(ena_q), 0);
        chk("R12 soft", 32'(srst_active), 0);
        chk("R5 rx idle", 32'(rx_vec_reg), 32'h00);
        chk("R5 tx idle", 32'(tx_vec_reg), 32'h0F);
        chk("R10 irq reset", 32'(irq), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk: R2 R3 R4 R5 R11 R10
        for (int v = 0; v < NV; v++) begin
            logic [N-1:0] s, e, d;
            {s, e, d} = VEC_TAB[v];
            ena_wr = 1; ena_wdata = e; dir_wr = 1; dir_wdata = d;
            flag_clr_wr = 1; flag_clr_mask = '1;
            edge_step();
            idle_inputs();
            flag_set = s;
            edge_step();
            idle_inputs();
            rc = s & e & ~d;
            tc = s & e & d;
            chk("R1 flags", 32'(flag_q), 32'(s));
            chk("R2/R11 rx vec", 32'(rx_vec_reg), 32'(ref_low(rc)));
            chk("R3/R11 tx vec", 32'(tx_vec_reg), 32'(ref_high(tc)));
            chk("R4 upper bits", 32'({rx_vec_reg[7:4], tx_vec_reg[7:4]}), 0);
            chk("R5 rx sum", 32'(rx_sum), 32'(rc != 0));
            chk("R5 tx sum", 32'(tx_sum), 32'(tc != 0));
            chk("R10 irq", 32'(irq), 32'((rc | tc) != 0));
        end

        // R1: set and clear together on bit 3, clear-all on the rest (dir AAAA)
        flag_set = 16'h0008; flag_clr_wr = 1; flag_clr_mask = '1;
        edge_step();
        idle_inputs();
        chk("R1 set wins", 32'(flag_q), 32'h0008);
        chk("R3 tx after collision", 32'(tx_vec_reg), 32'h03);
        flag_clr_wr = 1; flag_clr_mask = 16'h0008;
        edge_step();
        idle_inputs();
        chk("R1 clear", 32'(flag_q), 0);

        // R7: lock enable ignored in run mode, wake enable accepted
        ien_wr = 1; ien_lock_wdata = 1; ien_wake_wdata = 0;
        edge_step();
        idle_inputs();
        chk("R7 lock ignored", 32'(lock_en_q), 0);

        // R9: wake with enable off
        wake_req = 1;
        #2 chk("R9 wake masked", 32'(irq), 0);
        @(negedge clk);
        idle_inputs();

        ien_wr = 1; ien_lock_wdata = 0; ien_wake_wdata = 1;
        edge_step();
        idle_inputs();
        chk("R7 wake write", 32'(wake_en_q), 1);
        wake_req = 1;
        #2 chk("R9 wake irq", 32'(irq), 1);
        @(negedge clk);
        idle_inputs();

        // R6: enter soft reset
        flag_set = 16'h0003;
        edge_step();
        idle_inputs();
        srst_wr = 1; srst_wdata = 1;
        edge_step();
        idle_inputs();
        chk("R6 soft active", 32'(srst_active), 1);
        chk("R6 sums quiet", 32'({rx_sum, tx_sum}), 0);
        chk("R6 rx idle", 32'(rx_vec_reg), 32'h00);
        chk("R6 tx idle", 32'(tx_vec_reg), 32'h0F);
        flag_set = '1;
        ien_wr = 1; ien_lock_wdata = 1; ien_wake_wdata = 1;
        edge_step();
        idle_inputs();
        chk("R6 set ignored", 32'(flag_q), 0);
        chk("R7 lock in soft", 32'(lock_en_q), 1);
        srst_wr = 1; srst_wdata = 0;
        edge_step();
        idle_inputs();
        chk("R6 released", 32'(srst_active), 0);

        // R8: enabled locking error with a pending transmit buffer (bit 1, dir AAAA)
        flag_set = 16'h0002;
        edge_step();
        idle_inputs();
        chk("R3 pending", 32'(tx_vec_reg), 32'h01);
        lock_err = 1;
        #2 chk("R8 irq", 32'(irq), 1);
        @(negedge clk);
        idle_inputs();
        chk("R8 soft entered", 32'(srst_active), 1);
        chk("R8 summary cut", 32'(tx_sum), 0);
        ien_wr = 1; ien_lock_wdata = 0; ien_wake_wdata = 0;
        edge_step();
        idle_inputs();
        srst_wr = 1; srst_wdata = 0;
        edge_step();
        idle_inputs();
        chk("R7 lock cleared", 32'(lock_en_q), 0);
        lock_err = 1;
        #2 chk("R8 irq masked", 32'(irq), 0);
        @(negedge clk);
        idle_inputs();
        chk("R8 no soft", 32'(srst_active), 0);

        // R12: hard reset mid-run
        flag_set = 16'h0010; ena_wr = 1; ena_wdata = '1;
        edge_step();
        idle_inputs();
        rst_n = 0;
        #2;
        chk("R12 flags cleared", 32'(flag_q), 0);
        chk("R12 wake cleared", 32'(wake_en_q), 0);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        done = 1;
        summary();
        $finish;
    end
endmodule